// File: doc/BRIEF.md
# Oversampling Serial Receiver with Tagged Receive Queue

This block turns an asynchronous serial line into parallel characters. A local tick generator divides the system clock by the programmed divisor plus two. The receiver samples the line on every tick, which gives sixteen samples per bit. A start bit is accepted only if the line is still low at the middle of the bit. Each later bit is taken at its own centre. The character length, parity mode and stop-bit count are set through static configuration inputs.

Every completed character goes into a 16-entry first-in first-out queue. Each entry stores the character together with three error tags: parity mismatch, framing error and break. The head entry is always visible on the read outputs. A one-cycle read strobe removes it.

The block raises three interrupts:
- a threshold interrupt, when the fill level reaches a selected value;
- a timeout interrupt, when data has sat in the queue for four character times with nothing new arriving and nothing read;
- a line-status interrupt, on overrun or when the head entry carries an error tag.

Top module: `serial_rx_core`

## Requirements
- R1: The sample tick occurs once every `div_i + 2` clock cycles, and one bit lasts 16 ticks. Characters decode correctly with `div_i` = 0 (32 clocks per bit) and `div_i` = 3 (80 clocks per bit).
- R2: A low pulse on `rx_i` shorter than half a bit is rejected as a false start. It writes no entry.
- R3: `len_sel_i` selects 5, 6, 7 or 8 data bits for codes 0, 1, 2 and 3. Data is received least significant bit first. It appears right-justified on `rd_data_o`, with unused upper bits read as zero.
- R4: `par_sel_i` selects the parity mode: 0 = none, 1 = odd, 2 = even, 3 = none. When parity is enabled, a parity bit follows the data. A mismatch sets `rd_par_err_o` on that entry only.
- R5: A first stop bit sampled low sets `rd_frm_err_o` on that entry. The receiver then waits for the line to return high before it looks for a new start bit. When `stop2_i` = 1, the entry is written after a second stop bit.
- R6: A frame whose data, parity and first stop bit are all zero is a break. It writes exactly one entry with data 0 and both `rd_brk_o` and `rd_frm_err_o` set, however long the line stays low.
- R7: The queue holds 16 entries and returns them in arrival order. The head entry is shown on the read outputs. `rd_i` removes it and lowers `level_o` by one. A read of an empty queue has no effect on `level_o`.
- R8: A character that completes while the queue holds 16 entries is discarded and sets `overrun_o`. Any `rd_i` pulse clears `overrun_o`.
- R9: `irq_thr_o` is high exactly while `level_o` is at least the threshold selected by `thr_sel_i`: 1, 4, 8 or 14 for codes 0 to 3.
- R10: `irq_tout_o` rises once the queue has been non-empty for 64 × (frame bits) ticks with no write and no read. A read clears it, and it is never high while the queue is empty.
- R11: `irq_line_o` is high while `overrun_o` is set, or while the queue is non-empty and its head entry carries any error tag.
- R12: After reset, `level_o` is 0 and `overrun_o`, `irq_thr_o`, `irq_tout_o` and `irq_line_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| rx_i | input | 1 | Asynchronous serial line, idle high |
| div_i | input | DIV_W | Divisor; tick period is div_i + 2 clocks |
| len_sel_i | input | 2 | Data bits: 0=5, 1=6, 2=7, 3=8 |
| par_sel_i | input | 2 | Parity: 0 none, 1 odd, 2 even, 3 none |
| stop2_i | input | 1 | 1 selects two stop bits |
| thr_sel_i | input | 2 | Threshold: 0=1, 1=4, 2=8, 3=14 entries |
| rd_i | input | 1 | Pop strobe for the head entry |
| rd_data_o | output | 8 | Head entry character |
| rd_par_err_o | output | 1 | Head entry parity error tag |
| rd_frm_err_o | output | 1 | Head entry framing error tag |
| rd_brk_o | output | 1 | Head entry break tag |
| level_o | output | LVL_W | Number of stored entries |
| overrun_o | output | 1 | Sticky overrun flag, cleared by a read |
| irq_thr_o | output | 1 | Threshold interrupt |
| irq_tout_o | output | 1 | Character timeout interrupt |
| irq_line_o | output | 1 | Line status interrupt |

## Verification
The bench probes the following corner cases:
- A short low glitch on an idle line. A design that skips the mid-bit check would log a bogus character.
- A long break. A design that keeps re-arming on a low line would fill the queue with zero entries instead of one.
- A 17th character arriving at a full queue. Overwriting the tail, or failing to flag the loss, both show up as a queue that no longer matches the arrival order.
- Short character lengths, which expose shifting the data to the wrong end.
- Deliberately wrong parity and stop bits, which expose tags attached to the wrong entry.
- The timeout, which is checked just before and just after its window, so a counter that is off by a character time is caught.

// File: rtl/urx_pkg.sv
`timescale 1ns/1ps
package urx_pkg;

    typedef enum logic [1:0] {
        PAR_NONE = 2'd0,
        PAR_ODD  = 2'd1,
        PAR_EVEN = 2'd2,
        PAR_OFF  = 2'd3
    } par_mode_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_DATA,
        S_PAR,
        S_STOP,
        S_STOP2,
        S_WAITHI
    } rx_state_e;

    typedef struct packed {
        logic       brk;
        logic       frm;
        logic       par;
        logic [7:0] data;
    } rx_entry_t;

    localparam int unsigned OVERSAMPLE = 16;
    localparam int unsigned TOUT_CHARS = 4;

    function automatic logic [3:0] data_bits(input logic [1:0] sel);
        return 4'd5 + {2'b00, sel};
    endfunction

    function automatic logic parity_on(input par_mode_e pm);
        return (pm == PAR_ODD) || (pm == PAR_EVEN);
    endfunction

    function automatic logic [3:0] frame_bits(input logic [1:0] sel,
                                              input par_mode_e pm,
                                              input logic      two_stop);
        return 4'd2 + data_bits(sel) + {3'b000, parity_on(pm)} + {3'b000, two_stop};
    endfunction

    function automatic int unsigned thr_level(input logic [1:0] sel);
        case (sel)
            2'd0:    return 1;
            2'd1:    return 4;
            2'd2:    return 8;
            default: return 14;
        endcase
    endfunction

endpackage

// File: rtl/urx_baud.sv
`timescale 1ns/1ps
module urx_baud #(
    parameter int DIV_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    localparam int CW = DIV_W + 1;

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] last;

    assign last   = {1'b0, div_i} + CW'(1);
    assign tick_o = (cnt_q >= last);

    always_ff @(posedge clk_i) begin
        if (rst_i)       cnt_q <= '0;
        else if (tick_o) cnt_q <= '0;
        else             cnt_q <= cnt_q + CW'(1);
    end
endmodule

// File: rtl/urx_frame.sv
`timescale 1ns/1ps
module urx_frame
    import urx_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_i,
    input  logic      rx_i,
    input  logic      tick_i,
    input  logic [1:0] len_sel_i,
    input  logic [1:0] par_sel_i,
    input  logic      stop2_i,
    output logic      wr_o,
    output rx_entry_t wr_entry_o
);
    localparam logic [3:0] MID_SMP = 4'(OVERSAMPLE / 2 - 1);
    localparam logic [3:0] END_SMP = 4'(OVERSAMPLE - 1);

    logic [1:0] sync_q;
    logic       rx_s;
    rx_state_e  state_q;
    logic [3:0] scnt_q;
    logic [3:0] bcnt_q;
    logic [7:0] shreg_q;
    logic       pbit_q;
    logic       stop1_q;

    par_mode_e  pm;
    logic [3:0] nbits;
    logic       centre;
    logic       stop_v;
    rx_entry_t  entry;

    assign rx_s   = sync_q[1];
    assign pm     = par_mode_e'(par_sel_i);
    assign nbits  = data_bits(len_sel_i);
    assign centre = tick_i && (scnt_q == END_SMP);
    assign stop_v = (state_q == S_STOP) ? rx_s : stop1_q;

    always_comb begin
        entry.data = shreg_q;
        entry.frm  = !stop_v;
        entry.par  = parity_on(pm) && ((^shreg_q) ^ pbit_q ^ (pm == PAR_ODD));
        entry.brk  = (shreg_q == 8'd0) && !pbit_q && !stop_v;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) sync_q <= 2'b11;
        else       sync_q <= {sync_q[0], rx_i};
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q    <= S_IDLE;
            scnt_q     <= '0;
            bcnt_q     <= '0;
            shreg_q    <= '0;
            pbit_q     <= 1'b0;
            stop1_q    <= 1'b1;
            wr_o       <= 1'b0;
            wr_entry_o <= '0;
        end else begin
            wr_o <= 1'b0;
            if (tick_i && state_q != S_IDLE && state_q != S_WAITHI)
                scnt_q <= centre ? 4'd0 : scnt_q + 4'd1;
            case (state_q)
                S_IDLE: begin
                    if (!rx_s) begin
                        state_q <= S_START;
                        scnt_q  <= '0;
                    end
                end
                S_START: begin
                    if (tick_i && scnt_q == MID_SMP) begin
                        scnt_q <= '0;
                        if (!rx_s) begin
                            state_q <= S_DATA;
                            bcnt_q  <= '0;
                            shreg_q <= '0;
                            pbit_q  <= 1'b0;
                        end else begin
                            state_q <= S_IDLE;
                        end
                    end
                end
                S_DATA: begin
                    if (centre) begin
                        shreg_q[bcnt_q[2:0]] <= rx_s;
                        if (bcnt_q == nbits - 4'd1)
                            state_q <= parity_on(pm) ? S_PAR : S_STOP;
                        else
                            bcnt_q <= bcnt_q + 4'd1;
                    end
                end
                S_PAR: begin
                    if (centre) begin
                        pbit_q  <= rx_s;
                        state_q <= S_STOP;
                    end
                end
                S_STOP: begin
                    if (centre) begin
                        stop1_q <= rx_s;
                        if (stop2_i) begin
                            state_q <= S_STOP2;
                        end else begin
                            wr_o       <= 1'b1;
                            wr_entry_o <= entry;
                            state_q    <= rx_s ? S_IDLE : S_WAITHI;
                        end
                    end
                end
                S_STOP2: begin
                    if (centre) begin
                        wr_o       <= 1'b1;
                        wr_entry_o <= entry;
                        state_q    <= rx_s ? S_IDLE : S_WAITHI;
                    end
                end
                S_WAITHI: begin
                    if (rx_s) state_q <= S_IDLE;
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/urx_fifo.sv
`timescale 1ns/1ps
module urx_fifo
    import urx_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH),
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             wr_i,
    input  rx_entry_t        wr_entry_i,
    input  logic             rd_i,
    output rx_entry_t        head_o,
    output logic [LVL_W-1:0] level_o,
    output logic             overrun_o
);
    rx_entry_t        mem_q [DEPTH];
    logic [AW-1:0]    wptr_q, rptr_q;
    logic [LVL_W-1:0] cnt_q;
    logic             full, empty, do_rd, do_wr, ovr_set;

    assign full    = (cnt_q == LVL_W'(DEPTH));
    assign empty   = (cnt_q == '0);
    assign do_rd   = rd_i && !empty;
    assign do_wr   = wr_i && (!full || do_rd);
    assign ovr_set = wr_i && full && !do_rd;

    assign head_o  = mem_q[rptr_q];
    assign level_o = cnt_q;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk_i) begin
        if (do_wr) mem_q[wptr_q] <= wr_entry_i;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            wptr_q    <= '0;
            rptr_q    <= '0;
            cnt_q     <= '0;
            overrun_o <= 1'b0;
        end else begin
            if (do_wr) wptr_q <= bump(wptr_q);
            if (do_rd) rptr_q <= bump(rptr_q);
            case ({do_wr, do_rd})
                2'b10:   cnt_q <= cnt_q + LVL_W'(1);
                2'b01:   cnt_q <= cnt_q - LVL_W'(1);
                default: cnt_q <= cnt_q;
            endcase
            if (ovr_set)   overrun_o <= 1'b1;
            else if (rd_i) overrun_o <= 1'b0;
        end
    end
endmodule

// File: rtl/urx_timeout.sv
`timescale 1ns/1ps
module urx_timeout #(
    parameter int TO_W = 12
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic            tick_i,
    input  logic            nonempty_i,
    input  logic            activity_i,
    input  logic [TO_W-1:0] limit_i,
    output logic            tout_o
);
    logic [TO_W-1:0] cnt_q;

    assign tout_o = nonempty_i && (cnt_q >= limit_i);

    always_ff @(posedge clk_i) begin
        if (rst_i || activity_i || !nonempty_i) cnt_q <= '0;
        else if (tick_i && cnt_q < limit_i)     cnt_q <= cnt_q + TO_W'(1);
    end
endmodule

// File: rtl/serial_rx_core.sv
`timescale 1ns/1ps
module serial_rx_core
    import urx_pkg::*;
#(
    parameter int DIV_W = 16,
    parameter int DEPTH = 16,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             rx_i,
    input  logic [DIV_W-1:0] div_i,
    input  logic [1:0]       len_sel_i,
    input  logic [1:0]       par_sel_i,
    input  logic             stop2_i,
    input  logic [1:0]       thr_sel_i,
    input  logic             rd_i,
    output logic [7:0]       rd_data_o,
    output logic             rd_par_err_o,
    output logic             rd_frm_err_o,
    output logic             rd_brk_o,
    output logic [LVL_W-1:0] level_o,
    output logic             overrun_o,
    output logic             irq_thr_o,
    output logic             irq_tout_o,
    output logic             irq_line_o
);
    localparam int AW    = $clog2(DEPTH);
    localparam int TO_W  = 12;
    localparam int SHIFT = $clog2(OVERSAMPLE * TOUT_CHARS);

    logic       tick;
    logic       wr;
    rx_entry_t  wr_entry;
    rx_entry_t  head;
    logic       nonempty;
    logic [TO_W-1:0] tout_limit;

    urx_baud #(.DIV_W(DIV_W)) baud_i (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .div_i (div_i),
        .tick_o(tick)
    );

    urx_frame frame_i (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .rx_i      (rx_i),
        .tick_i    (tick),
        .len_sel_i (len_sel_i),
        .par_sel_i (par_sel_i),
        .stop2_i   (stop2_i),
        .wr_o      (wr),
        .wr_entry_o(wr_entry)
    );

    urx_fifo #(.DEPTH(DEPTH), .AW(AW), .LVL_W(LVL_W)) fifo_i (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .wr_i      (wr),
        .wr_entry_i(wr_entry),
        .rd_i      (rd_i),
        .head_o    (head),
        .level_o   (level_o),
        .overrun_o (overrun_o)
    );

    assign nonempty   = (level_o != '0);
    assign tout_limit = TO_W'(frame_bits(len_sel_i, par_mode_e'(par_sel_i), stop2_i)) << SHIFT;

    urx_timeout #(.TO_W(TO_W)) tout_i (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .tick_i    (tick),
        .nonempty_i(nonempty),
        .activity_i(wr || rd_i),
        .limit_i   (tout_limit),
        .tout_o    (irq_tout_o)
    );

    assign rd_data_o    = head.data;
    assign rd_par_err_o = head.par;
    assign rd_frm_err_o = head.frm;
    assign rd_brk_o     = head.brk;

    assign irq_thr_o  = (level_o >= LVL_W'(thr_level(thr_sel_i)));
    assign irq_line_o = overrun_o || (nonempty && (head.par || head.frm || head.brk));
endmodule

// File: rtl/serial_rx_core_chk.sv
`timescale 1ns/1ps
module serial_rx_core_chk #(
    parameter int DEPTH = 16,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic             rd_i,
    input logic [LVL_W-1:0] level_o,
    input logic             overrun_o,
    input logic             irq_tout_o,
    input logic             rd_brk_o,
    input logic             rd_frm_err_o,
    input logic [7:0]       rd_data_o
);
    // R7
    a_r7_level_bound: assert property (@(posedge clk_i) disable iff (rst_i)
        level_o <= LVL_W'(DEPTH));

    // R7
    a_r7_single_step_up: assert property (@(posedge clk_i) disable iff (rst_i)
        (level_o > $past(level_o)) |-> (level_o == $past(level_o) + LVL_W'(1)));

    // R7
    a_r7_drop_needs_read: assert property (@(posedge clk_i) disable iff (rst_i)
        (level_o < $past(level_o)) |-> $past(rd_i));

    // R8
    a_r8_overrun_only_when_full: assert property (@(posedge clk_i) disable iff (rst_i)
        (overrun_o && !$past(overrun_o)) |-> ($past(level_o) == LVL_W'(DEPTH)));

    // R10
    a_r10_tout_needs_data: assert property (@(posedge clk_i) disable iff (rst_i)
        irq_tout_o |-> (level_o != '0));

    // R10
    a_r10_read_clears_tout: assert property (@(posedge clk_i) disable iff (rst_i)
        ($past(rd_i) && $past(level_o) != '0) |-> !irq_tout_o);

    // R6
    a_r6_break_shape: assert property (@(posedge clk_i) disable iff (rst_i)
        (rd_brk_o && level_o != '0) |-> (rd_frm_err_o && rd_data_o == 8'd0));
endmodule

bind serial_rx_core serial_rx_core_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W)) chk_i (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .rd_i        (rd_i),
    .level_o     (level_o),
    .overrun_o   (overrun_o),
    .irq_tout_o  (irq_tout_o),
    .rd_brk_o    (rd_brk_o),
    .rd_frm_err_o(rd_frm_err_o),
    .rd_data_o   (rd_data_o)
);

// File: tb/serial_rx_core_tb_top.sv
`timescale 1ns/1ps
module serial_rx_core_tb_top;
    localparam int DIV_W = 16;
    localparam int DEPTH = 16;
    localparam int LVL_W = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic             rst = 1'b1;
    logic             rx = 1'b1;
    logic [DIV_W-1:0] div = '0;
    logic [1:0]       len_sel = 2'd3;
    logic [1:0]       par_sel = 2'd0;
    logic             stop2 = 1'b0;
    logic [1:0]       thr_sel = 2'd0;
    logic             rd = 1'b0;
    logic [7:0]       rd_data_o;
    logic             rd_par_err_o, rd_frm_err_o, rd_brk_o;
    logic [LVL_W-1:0] level_o;
    logic             overrun_o, irq_thr_o, irq_tout_o, irq_line_o;

    serial_rx_core #(.DIV_W(DIV_W), .DEPTH(DEPTH)) dut_i (
        .clk_i(clk), .rst_i(rst), .rx_i(rx), .div_i(div),
        .len_sel_i(len_sel), .par_sel_i(par_sel), .stop2_i(stop2),
        .thr_sel_i(thr_sel), .rd_i(rd),
        .rd_data_o(rd_data_o), .rd_par_err_o(rd_par_err_o),
        .rd_frm_err_o(rd_frm_err_o), .rd_brk_o(rd_brk_o),
        .level_o(level_o), .overrun_o(overrun_o), .irq_thr_o(irq_thr_o),
        .irq_tout_o(irq_tout_o), .irq_line_o(irq_line_o)
    );

    int  errs = 0;
    int  checks = 0;
    bit  quiet = 1'b0;
    bit  done = 1'b0;
    int  bitclk = 32;
    logic [10:0] mq[$];   // {brk, frm, par, data}
    bit  movr = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int thr_of(input logic [1:0] s);
        case (s)
            2'd0: return 1;
            2'd1: return 4;
            2'd2: return 8;
            default: return 14;
        endcase
    endfunction

    function automatic bit model_line();
        if (movr) return 1'b1;
        if (mq.size() == 0) return 1'b0;
        return |mq[0][10:8];
    endfunction

    // Reference model comparison while the line and read strobe are quiet
    always @(negedge clk) begin
        if (quiet) begin
            chk(int'(level_o) == mq.size(), "R7", "level", int'(level_o), mq.size());
            chk(irq_thr_o == (mq.size() >= thr_of(thr_sel)), "R9", "irq_thr",
                int'(irq_thr_o), int'(mq.size() >= thr_of(thr_sel)));
            chk(overrun_o == movr, "R8", "overrun", int'(overrun_o), int'(movr));
            chk(irq_line_o == model_line(), "R11", "irq_line",
                int'(irq_line_o), int'(model_line()));
        end
    end

    task automatic drive(input logic v);
        rx = v;
        repeat (bitclk) @(negedge clk);
    endtask

    task automatic idle(input int n);
        quiet = 1'b1;
        repeat (n) @(negedge clk);
        quiet = 1'b0;
    endtask

    task automatic push_exp(input logic [10:0] e);
        if (mq.size() == DEPTH) movr = 1'b1;
        else mq.push_back(e);
    endtask

    task automatic send_frame(input logic [7:0] d, input int nb, input int pm,
                              input bit s2, input bit badp, input bit stopv);
        logic [7:0] m;
        logic p;
        m = d & 8'((1 << nb) - 1);
        len_sel = 2'(nb - 5);
        par_sel = 2'(pm);
        stop2 = s2;
        drive(1'b0);
        for (int i = 0; i < nb; i++) drive(m[i]);
        if (pm == 1 || pm == 2) begin
            p = ^m;
            if (pm == 1) p = ~p;
            if (badp) p = ~p;
            drive(p);
        end
        drive(stopv);
        if (s2) drive(1'b1);
        push_exp({1'b0, !stopv, badp && (pm == 1 || pm == 2), m});
        if (!stopv) drive(1'b1);
    endtask

    task automatic read_one(input string req);
        logic [10:0] got;
        quiet = 1'b0;
        got = {rd_brk_o, rd_frm_err_o, rd_par_err_o, rd_data_o};
        if (mq.size() != 0)
            chk(got == mq[0], req, "head entry", int'(got), int'(mq[0]));
        rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
        if (mq.size() != 0) void'(mq.pop_front());
        movr = 1'b0;
    endtask

    task automatic drain(input string req);
        while (mq.size() != 0) begin
            read_one(req);
            idle(2);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        repeat (6) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12 reset state
        chk(level_o == '0, "R12", "level", int'(level_o), 0);
        chk(!overrun_o && !irq_thr_o && !irq_tout_o && !irq_line_o, "R12", "flags",
            int'({overrun_o, irq_thr_o, irq_tout_o, irq_line_o}), 0);
        idle(8);

        // R1 / R7: basic 8N1 at divisor 0, order preserved
        thr_sel = 2'd0;
        send_frame(8'hA5, 8, 0, 0, 0, 1); idle(4);
        send_frame(8'h3C, 8, 0, 0, 0, 1); idle(4);
        read_one("R7"); idle(2);
        read_one("R1"); idle(2);

        // R7: read of empty queue ignored
        read_one("R7"); idle(1);
        chk(level_o == '0, "R7", "empty read level", int'(level_o), 0);

        // R3: short lengths right-justified
        send_frame(8'hFF, 5, 0, 0, 0, 1); idle(3);
        send_frame(8'hFF, 6, 0, 0, 0, 1); idle(3);
        send_frame(8'hD6, 7, 0, 0, 0, 1); idle(3);
        drain("R3");

        // R4: parity modes, good and bad
        send_frame(8'h5B, 8, 1, 0, 0, 1); idle(3);
        send_frame(8'h5B, 8, 1, 0, 1, 1); idle(3);
        send_frame(8'h81, 8, 2, 0, 0, 1); idle(3);
        send_frame(8'h81, 8, 2, 0, 1, 1); idle(3);
        send_frame(8'h81, 8, 3, 0, 0, 1); idle(3);
        drain("R4");

        // R5: framing error, then two stop bits
        send_frame(8'h42, 8, 0, 0, 0, 0); idle(3);
        send_frame(8'h99, 8, 0, 1, 0, 1); idle(3);
        send_frame(8'h17, 8, 2, 1, 0, 0); idle(3);
        drain("R5");

        // R6: long break gives one entry
        len_sel = 2'd3; par_sel = 2'd0; stop2 = 1'b0;
        rx = 1'b0;
        repeat (25 * bitclk) @(negedge clk);
        rx = 1'b1;
        push_exp({1'b1, 1'b1, 1'b0, 8'h00});
        repeat (2 * bitclk) @(negedge clk);
        idle(4);
        chk(int'(level_o) == 1, "R6", "break entries", int'(level_o), 1);
        drain("R6");

        // R2: glitch shorter than half a bit
        rx = 1'b0;
        repeat (8) @(negedge clk);
        rx = 1'b1;
        repeat (3 * bitclk) @(negedge clk);
        idle(4);
        chk(level_o == '0, "R2", "glitch entries", int'(level_o), 0);

        // R1: divisor 3
        div = 16'd3; bitclk = 80;
        idle(10);
        send_frame(8'hC3, 8, 2, 0, 0, 1); idle(3);
        send_frame(8'h0E, 8, 0, 0, 0, 1); idle(3);
        drain("R1");
        div = 16'd0; bitclk = 32;
        idle(10);

        // R10: timeout window for 8N1 (10 bits -> 640 ticks -> 1280 clocks)
        send_frame(8'h6D, 8, 0, 0, 0, 1);
        chk(!irq_tout_o, "R10", "tout early", int'(irq_tout_o), 0);
        repeat (1280 - 64) @(negedge clk);
        chk(!irq_tout_o, "R10", "tout before window", int'(irq_tout_o), 0);
        repeat (128) @(negedge clk);
        chk(irq_tout_o, "R10", "tout after window", int'(irq_tout_o), 1);
        read_one("R10");
        chk(!irq_tout_o, "R10", "tout after read", int'(irq_tout_o), 0);
        idle(4);

        // R8 / R9: fill beyond capacity with rotating thresholds
        for (int k = 0; k < 17; k++) begin
            send_frame(8'(k + 1), 8, 0, 0, 0, 1);
            thr_sel = 2'(k % 4);
            idle(3);
        end
        chk(int'(level_o) == DEPTH, "R8", "full level", int'(level_o), DEPTH);
        chk(overrun_o, "R8", "overrun set", int'(overrun_o), 1);
        chk(irq_line_o, "R11", "line on overrun", int'(irq_line_o), 1);
        thr_sel = 2'd3;
        idle(2);
        read_one("R8");
        idle(1);
        chk(!overrun_o, "R8", "overrun cleared", int'(overrun_o), 0);
        drain("R8");
        idle(4);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule